// File: doc/BRIEF.md
# ISA I/O Slave Window Decoder

This block sits behind the pads of a peripheral that occupies a 32-byte window of ISA I/O space. It decides whether a cycle belongs to this peripheral, which of the two data byte lanes carry it, and whether the cycle must be stretched. The base of the window comes from five strap inputs. A strap that is grounded makes its address line compare against 0. A strap that is left open, and so is pulled up, compares against 1. The five low address bits pick the register inside the window.

Lane steering depends on the 8/16-bit sense input, the byte-high-enable input and the low address bits. A 16-bit access to the FIFO index carries two FIFOs at once, one per lane. A bus that is only 8 bits wide has every access folded onto the low lane. Any other combination is rejected.

For the register file behind it, the block produces:
- a captured register index;
- single-cycle read and write strobes for each lane;
- output enables for the lane drivers;
- the 16-bit select, active low;
- a pull-low request for the open-collector ready line, which holds the host in wait states while the target reports busy.

Top module: `isa_io_decode`

## Requirements
- R1: The block is selected only while `aen_n` is 0 and `sa[9:5]` equals `base_strap`. When it is not selected, no drive enable, strobe or illegal pulse is produced, and `cs16_n` stays 1.
- R2: Each strap bit is compared with its address bit as a plain value. With `base_strap` = 5'b10110 the window is I/O addresses 0x2C0 to 0x2DF.
- R3: A 16-bit access (`sense_8_16n`=0, `bhe_n`=0) at index 5'b11000 enables both lanes and sets `fifo_split`=1. In that case the high lane carries FIFO A and the low lane carries FIFO B.
- R4: A 16-bit access (`sense_8_16n`=0, `bhe_n`=0) at an odd index (bit 0 = 1) enables only the high lane.
- R5: An access with `sense_8_16n`=0, `bhe_n`=1 and an even index enables only the low lane.
- R6: With `sense_8_16n`=1 and `bhe_n`=1, every index uses only the low lane, and the high lane is never driven.
- R7: Every other lane combination enables no lane. `illegal_access` is 1 for exactly one clock, in the cycle after the clock edge that first samples the strobe low.
- R8: `cs16_n` is 0, without a clock, exactly while the block is selected and the decoded access uses the high lane.
- R9: The write strobe for each lane is 1 for one clock, in the cycle after the clock edge that first samples `iow_n` high again. It uses the lanes and the index captured when `iow_n` fell, even if the address has since changed.
- R10: Each falling edge of `ior_n` during a selected access gives a one-clock read strobe on each active lane. The strobe appears in the cycle after the clock edge that samples `ior_n` low. The lane output enables follow `ior_n` without a clock.
- R11: If `tgt_busy` is 1 when a selected access starts, `rdy_pull_low` is 1 for exactly WAIT_CLKS clocks (default 4), starting in the cycle after the start edge. It stays 0 when the target is not busy, and it is released as soon as both strobes are high.
- R12: While reset is held, all strobes, `illegal_access`, `fifo_split` and `rdy_pull_low` are 0, and `reg_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sa | input | 10 | I/O address from the host |
| aen_n | input | 1 | Address enable, active low (0 = I/O cycle allowed) |
| sense_8_16n | input | 1 | 0 = 16-bit host bus, 1 = 8-bit host bus |
| bhe_n | input | 1 | Byte-high enable, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| base_strap | input | 5 | Window base straps, compared with sa[9:5] |
| tgt_busy | input | 1 | Target register not ready |
| reg_idx | output | 5 | Register index captured at the strobe's falling edge |
| fifo_split | output | 1 | Captured access splits FIFO A (high) and FIFO B (low) |
| hi_rd_en | output | 1 | High-lane read strobe |
| lo_rd_en | output | 1 | Low-lane read strobe |
| hi_wr_en | output | 1 | High-lane write strobe |
| lo_wr_en | output | 1 | Low-lane write strobe |
| hi_drv_en | output | 1 | High-lane output driver enable |
| lo_drv_en | output | 1 | Low-lane output driver enable |
| cs16_n | output | 1 | 16-bit select, active low |
| rdy_pull_low | output | 1 | Pull the open-collector ready line low |
| illegal_access | output | 1 | One-clock pulse on an illegal lane combination |

## Verification
The checker assumes that the host never holds `ior_n` and `iow_n` low at the same time. It also assumes that each strobe stays high for at least one clock between accesses, and that the address, `aen_n` and lane inputs are steady from one clock before a strobe falls until it rises again. Under those conditions the strobe pulses are single cycles and every wait stretch lies inside an access. The bench drives all of these inputs only on the falling clock edge, as whole access tasks. Each task sets the address first and opens the strobe one clock later. The write task is the one exception: it changes the address deliberately on the same edge at which `iow_n` returns high, to show that the index captured at the start is the one used.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
   // Lane decision for one access
   typedef struct packed {
      logic hi;       // high byte lane carries data
      logic lo;       // low byte lane carries data
      logic split;    // both lanes, two FIFOs
      logic bad;      // combination not allowed
   } lane_sel_t;
endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
   parameter int ADDR_W = 10,
   parameter int IDX_W  = 5,
   localparam int BASE_W = ADDR_W - IDX_W
) (
   input  logic [ADDR_W-1:0] sa,
   input  logic              aen_n,
   input  logic [BASE_W-1:0] base_strap,
   output logic              sel,
   output logic [IDX_W-1:0]  idx
);
   assign sel = !aen_n && (sa[ADDR_W-1:IDX_W] == base_strap);
   assign idx = sa[IDX_W-1:0];
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
   import isa_dec_pkg::*;
#(
   parameter int          IDX_W    = 5,
   parameter logic [IDX_W-1:0] FIFO_IDX = 5'b11000
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             sense_8_16n,
   input  logic             bhe_n,
   output lane_sel_t        lanes
);
   always_comb begin
      lanes = '0;
      unique case ({sense_8_16n, bhe_n})
         2'b00: begin
            if (idx == FIFO_IDX) begin
               lanes.hi    = 1'b1;
               lanes.lo    = 1'b1;
               lanes.split = 1'b1;
            end else if (idx[0]) begin
               lanes.hi = 1'b1;
            end else begin
               lanes.bad = 1'b1;
            end
         end
         2'b01: begin
            if (!idx[0]) lanes.lo = 1'b1;
            else         lanes.bad = 1'b1;
         end
         2'b11:   lanes.lo  = 1'b1;
         default: lanes.bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/isa_wait_seq.sv
module isa_wait_seq #(
   parameter int WAIT_CLKS = 4,
   localparam int CNT_W = (WAIT_CLKS < 1) ? 1 : $clog2(WAIT_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic idle,
   output logic pull_low
);
   generate
      if (WAIT_CLKS == 0) begin : g_nowait
         assign pull_low = 1'b0;
      end else begin : g_wait
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (idle)           cnt <= '0;
            else if (start && busy)  cnt <= CNT_W'(WAIT_CLKS);
            else if (cnt != '0)      cnt <= cnt - 1'b1;
         end
         assign pull_low = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/isa_io_decode.sv
module isa_io_decode
   import isa_dec_pkg::*;
#(
   parameter int               ADDR_W    = 10,
   parameter int               IDX_W     = 5,
   parameter logic [IDX_W-1:0] FIFO_IDX  = 5'b11000,
   parameter int               WAIT_CLKS = 4,
   localparam int              BASE_W    = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sa,
   input  logic              aen_n,
   input  logic              sense_8_16n,
   input  logic              bhe_n,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic [BASE_W-1:0] base_strap,
   input  logic              tgt_busy,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              fifo_split,
   output logic              hi_rd_en,
   output logic              lo_rd_en,
   output logic              hi_wr_en,
   output logic              lo_wr_en,
   output logic              hi_drv_en,
   output logic              lo_drv_en,
   output logic              cs16_n,
   output logic              rdy_pull_low,
   output logic              illegal_access
);
   generate
      if (IDX_W < 1 || ADDR_W <= IDX_W) begin : g_bad_width
         $error("isa_io_decode: ADDR_W must exceed IDX_W >= 1");
      end
      if (WAIT_CLKS < 0) begin : g_bad_wait
         $error("isa_io_decode: WAIT_CLKS must be non-negative");
      end
   endgenerate

   logic             sel;
   logic [IDX_W-1:0] idx;
   lane_sel_t        lanes;

   isa_addr_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
      .sa(sa), .aen_n(aen_n), .base_strap(base_strap), .sel(sel), .idx(idx)
   );

   isa_lane_steer #(.IDX_W(IDX_W), .FIFO_IDX(FIFO_IDX)) u_steer (
      .idx(idx), .sense_8_16n(sense_8_16n), .bhe_n(bhe_n), .lanes(lanes)
   );

   // Strobe history for edge detection
   logic ior_q, iow_q;
   logic rd_fall, wr_fall, wr_rise, any_fall;
   assign rd_fall  = ior_q && !ior_n;
   assign wr_fall  = iow_q && !iow_n;
   assign wr_rise  = !iow_q && iow_n;
   assign any_fall = rd_fall || wr_fall;

   // Lanes latched for the write, used at the trailing edge
   logic wl_hi, wl_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ior_q          <= 1'b1;
         iow_q          <= 1'b1;
         reg_idx        <= '0;
         fifo_split     <= 1'b0;
         wl_hi          <= 1'b0;
         wl_lo          <= 1'b0;
         hi_rd_en       <= 1'b0;
         lo_rd_en       <= 1'b0;
         hi_wr_en       <= 1'b0;
         lo_wr_en       <= 1'b0;
         illegal_access <= 1'b0;
      end else begin
         ior_q          <= ior_n;
         iow_q          <= iow_n;
         hi_rd_en       <= rd_fall && sel && lanes.hi;
         lo_rd_en       <= rd_fall && sel && lanes.lo;
         hi_wr_en       <= wr_rise && wl_hi;
         lo_wr_en       <= wr_rise && wl_lo;
         illegal_access <= any_fall && sel && lanes.bad;
         if (any_fall && sel) begin
            reg_idx    <= idx;
            fifo_split <= lanes.split;
         end
         if (wr_fall) begin
            wl_hi <= sel && lanes.hi;
            wl_lo <= sel && lanes.lo;
         end
      end
   end

   // Pad-side controls follow the bus without a clock
   assign hi_drv_en = sel && !ior_n && lanes.hi;
   assign lo_drv_en = sel && !ior_n && lanes.lo;
   assign cs16_n    = !(sel && lanes.hi);

   isa_wait_seq #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
      .clk(clk), .rst_n(rst_n),
      .start(any_fall && sel), .busy(tgt_busy),
      .idle(ior_n && iow_n), .pull_low(rdy_pull_low)
   );
endmodule

// File: rtl/isa_io_decode_chk.sv
module isa_io_decode_chk (
   input logic clk,
   input logic rst_n,
   input logic aen_n,
   input logic sense_8_16n,
   input logic bhe_n,
   input logic ior_n,
   input logic iow_n,
   input logic hi_rd_en,
   input logic lo_rd_en,
   input logic hi_wr_en,
   input logic lo_wr_en,
   input logic hi_drv_en,
   input logic lo_drv_en,
   input logic cs16_n,
   input logic rdy_pull_low,
   input logic illegal_access
);
   // R1: no drive and no 16-bit select without address enable
   a_r1_quiet_without_aen: assert property (@(posedge clk) disable iff (!rst_n)
      aen_n |-> (!hi_drv_en && !lo_drv_en && cs16_n));

   // R6: 8-bit host never sees the high lane
   a_r6_hi_lane_idle_8bit: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_8_16n && bhe_n) |-> (!hi_drv_en && cs16_n));

   // R7: illegal flag is a single pulse and comes with no read strobe
   a_r7_illegal_single: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_access |=> !illegal_access);
   a_r7_illegal_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_access |-> !(hi_rd_en || lo_rd_en));

   // R8: 16-bit select implies the window is enabled
   a_r8_cs16_needs_aen: assert property (@(posedge clk) disable iff (!rst_n)
      !cs16_n |-> !aen_n);

   // R9: write strobes last one clock and follow a high write strobe
   a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr_en || lo_wr_en) |=> !(hi_wr_en || lo_wr_en));
   a_r9_wr_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr_en || lo_wr_en) |-> $past(iow_n));

   // R10: read strobes come from a low read strobe and last one clock
   a_r10_rd_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd_en || lo_rd_en) |-> $past(!ior_n));
   a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd_en || lo_rd_en) |=> !(hi_rd_en || lo_rd_en));

   // R11: wait pull-low only inside an access
   a_r11_wait_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_pull_low |-> $past(!ior_n || !iow_n));
endmodule

bind isa_io_decode isa_io_decode_chk u_chk (
   .clk(clk), .rst_n(rst_n), .aen_n(aen_n), .sense_8_16n(sense_8_16n),
   .bhe_n(bhe_n), .ior_n(ior_n), .iow_n(iow_n),
   .hi_rd_en(hi_rd_en), .lo_rd_en(lo_rd_en),
   .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en),
   .hi_drv_en(hi_drv_en), .lo_drv_en(lo_drv_en), .cs16_n(cs16_n),
   .rdy_pull_low(rdy_pull_low), .illegal_access(illegal_access)
);

// File: tb/isa_io_decode_tb.sv
module isa_io_decode_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [9:0] BASE = 10'h2C0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [9:0] sa = '0;
   logic aen_n = 1'b1, sense_8_16n = 1'b0, bhe_n = 1'b1;
   logic ior_n = 1'b1, iow_n = 1'b1, tgt_busy = 1'b0;
   logic [4:0] base_strap = 5'b10110;
   logic [4:0] reg_idx;
   logic fifo_split, hi_rd_en, lo_rd_en, hi_wr_en, lo_wr_en;
   logic hi_drv_en, lo_drv_en, cs16_n, rdy_pull_low, illegal_access;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isa_io_decode u_dut (
      .clk(clk), .rst_n(rst_n), .sa(sa), .aen_n(aen_n),
      .sense_8_16n(sense_8_16n), .bhe_n(bhe_n), .ior_n(ior_n), .iow_n(iow_n),
      .base_strap(base_strap), .tgt_busy(tgt_busy), .reg_idx(reg_idx),
      .fifo_split(fifo_split), .hi_rd_en(hi_rd_en), .lo_rd_en(lo_rd_en),
      .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en), .hi_drv_en(hi_drv_en),
      .lo_drv_en(lo_drv_en), .cs16_n(cs16_n), .rdy_pull_low(rdy_pull_low),
      .illegal_access(illegal_access)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Read access: expected {hi,lo} lanes, illegal flag, wait clocks
   task automatic do_read(input string req, input logic [9:0] a, input logic s,
                          input logic b, input logic [1:0] exp_lanes,
                          input logic exp_bad, input int exp_wait);
      @(negedge clk);
      sa = a; aen_n = 1'b0; sense_8_16n = s; bhe_n = b;
      @(negedge clk);
      ior_n = 1'b0;
      #1;
      check({req, " drive"}, {hi_drv_en, lo_drv_en}, exp_lanes);
      check({req, " cs16_n"}, cs16_n, !exp_lanes[1]);
      @(negedge clk);
      check({req, " rd strobe"}, {hi_rd_en, lo_rd_en}, exp_lanes);
      check({req, " illegal"}, illegal_access, exp_bad);
      check({req, " R11 wait first"}, rdy_pull_low, exp_wait > 0);
      for (int i = 2; i <= 5; i++) begin
         @(negedge clk);
         if (i == 2) begin
            check({req, " rd one clock"}, {hi_rd_en, lo_rd_en}, 0);
            check({req, " illegal one clock"}, illegal_access, 0);
         end
         check({req, " R11 wait"}, rdy_pull_low, exp_wait >= i);
      end
      ior_n = 1'b1;
      @(negedge clk);
      aen_n = 1'b1;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R12 strobes", {hi_rd_en, lo_rd_en, hi_wr_en, lo_wr_en}, 0);
      check("R12 flags", {illegal_access, fifo_split, rdy_pull_low}, 0);
      check("R12 reg_idx", reg_idx, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_select();
      // R1: aen_n high, matching address
      @(negedge clk);
      sa = BASE | 10'd1; aen_n = 1'b1; sense_8_16n = 1'b0; bhe_n = 1'b0;
      @(negedge clk); ior_n = 1'b0; #1;
      check("R1 aen_n high drive", {hi_drv_en, lo_drv_en, !cs16_n}, 0);
      @(negedge clk);
      check("R1 aen_n high strobe", {hi_rd_en, lo_rd_en}, 0);
      ior_n = 1'b1;
      // R2: neighbour window 0x2E0 is outside, 0x2DF is inside
      @(negedge clk); sa = 10'h2E1; aen_n = 1'b0;
      @(negedge clk); ior_n = 1'b0; #1;
      check("R2 0x2E1 not selected", {hi_drv_en, lo_drv_en, !cs16_n}, 0);
      @(negedge clk); ior_n = 1'b1;
      check("R1 mismatch illegal", illegal_access, 0);
      @(negedge clk); sa = 10'h2DF;
      #1 check("R2 0x2DF selected cs16", cs16_n, 0);
      @(negedge clk); aen_n = 1'b1;
      #1 check("R8 cs16 release", cs16_n, 1);
   endtask

   task automatic t_fifo16();
      tgt_busy = 1'b1;
      do_read("R3 fifo split", BASE | 10'h18, 1'b0, 1'b0, 2'b11, 1'b0, 4);
      check("R3 fifo_split", fifo_split, 1);
      check("R3 reg_idx", reg_idx, 5'h18);
      tgt_busy = 1'b0;
   endtask

   task automatic t_wait_release();
      // R11: strobe ends after 2 clocks, pull-low released at once
      tgt_busy = 1'b1;
      @(negedge clk); sa = BASE | 10'h3; aen_n = 1'b0;
      sense_8_16n = 1'b0; bhe_n = 1'b0;
      @(negedge clk); ior_n = 1'b0;
      @(negedge clk); check("R11 early wait", rdy_pull_low, 1);
      ior_n = 1'b1;
      @(negedge clk); check("R11 release on idle", rdy_pull_low, 0);
      aen_n = 1'b1; tgt_busy = 1'b0;
   endtask

   task automatic t_write();
      @(negedge clk);
      sa = BASE | 10'h05; aen_n = 1'b0; sense_8_16n = 1'b0; bhe_n = 1'b0;
      @(negedge clk); iow_n = 1'b0;
      @(negedge clk);
      check("R9 no strobe while low", {hi_wr_en, lo_wr_en}, 0);
      @(negedge clk);
      iow_n = 1'b1; sa = BASE | 10'h02; bhe_n = 1'b1;  // address moves on
      @(negedge clk);
      check("R9 hi write strobe", {hi_wr_en, lo_wr_en}, 2'b10);
      check("R9 captured index", reg_idx, 5'h05);
      @(negedge clk);
      check("R9 strobe one clock", {hi_wr_en, lo_wr_en}, 0);
      // 8-bit write folds onto low lane
      sense_8_16n = 1'b1; bhe_n = 1'b1; sa = BASE | 10'h07;
      @(negedge clk); iow_n = 1'b0;
      @(negedge clk); iow_n = 1'b1;
      @(negedge clk);
      check("R6 8-bit write low lane", {hi_wr_en, lo_wr_en}, 2'b01);
      // unselected write: no strobe
      aen_n = 1'b1;
      @(negedge clk); iow_n = 1'b0;
      @(negedge clk); iow_n = 1'b1;
      @(negedge clk);
      check("R1 unselected write", {hi_wr_en, lo_wr_en}, 0);
   endtask

   initial begin
      t_reset();
      t_select();
      t_fifo16();
      do_read("R4 odd 16-bit", BASE | 10'h07, 1'b0, 1'b0, 2'b10, 1'b0, 0);
      do_read("R5 even byte", BASE | 10'h04, 1'b0, 1'b1, 2'b01, 1'b0, 0);
      do_read("R6 8-bit even", BASE | 10'h02, 1'b1, 1'b1, 2'b01, 1'b0, 0);
      do_read("R6 8-bit odd", BASE | 10'h0B, 1'b1, 1'b1, 2'b01, 1'b0, 0);
      do_read("R6 8-bit fifo", BASE | 10'h18, 1'b1, 1'b1, 2'b01, 1'b0, 0);
      check("R6 no split", fifo_split, 0);
      do_read("R7 even 16-bit", BASE | 10'h04, 1'b0, 1'b0, 2'b00, 1'b1, 0);
      do_read("R7 odd bhe high", BASE | 10'h09, 1'b0, 1'b1, 2'b00, 1'b1, 0);
      do_read("R7 8-bit bhe low", BASE | 10'h02, 1'b1, 1'b0, 2'b00, 1'b1, 0);
      tgt_busy = 1'b1;
      do_read("R10 odd busy", BASE | 10'h11, 1'b0, 1'b0, 2'b10, 1'b0, 4);
      tgt_busy = 1'b0;
      t_wait_release();
      t_write();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule